// File: doc/BRIEF.md
# Two-Stage Radix-4 Barrel Shifter with Selectable Fill

This block is a purely combinational 32-bit word shifter. It moves a data word left or right by 0 to 15 places in one pass, with no clock. The 4-bit count is split into two base-4 digits. The low digit drives a stage that moves the word by 0, 1, 2 or 3 places. The high digit drives a second stage that moves it by 0, 4, 8 or 12 places. Each output bit of each stage is a single 4-input multiplexer, so the tree uses 64 such cells in total.

The bits that empty out during a shift are loaded from a fill source chosen by the mode. A left shift always loads zeros, so the result equals the input multiplied by two to the count, modulo 2^32. A logical right shift loads zeros, which gives unsigned division by a power of two. An arithmetic right shift loads copies of the input's sign bit. For an inexact quotient, that result rounds toward negative infinity.

The block sits in a datapath wherever a shifted operand is needed. The caller presents the word, the count and the two mode bits, and reads the result combinationally.

Top module: `barrel_fill_shifter`

## Requirements
- R1: With a count of 0, the result equals the input word in every combination of the direction and signedness selects.
- R2: With `dir_i` = 0 (left), the result equals the input multiplied by 2^count, modulo 2^32. The `count_i` low-order result bits are zero.
- R3: With `dir_i` = 1 and `arith_i` = 0 (logical right), the result equals the unsigned input divided by 2^count and truncated. The `count_i` high-order result bits are zero.
- R4: With `dir_i` = 1 and `arith_i` = 1 (arithmetic right), the `count_i` high-order result bits equal input bit 31. The remaining bits are the input shifted right by the count.
- R5: An arithmetic right shift of a negative value rounds toward negative infinity. For example, 0xFFFFFFFB (-5) shifted by 1 gives 0xFFFFFFFD (-3).
- R6: When `dir_i` = 0, `arith_i` has no effect: a left shift gives the same result for either value of `arith_i`.
- R7: The maximum count of 15 is handled exactly in every mode. The low digit alone (counts 1 to 3), the high digit alone (counts 4, 8 and 12) and both digits together all give the full shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 32 | Word to be shifted |
| count_i | input | 4 | Shift distance, 0 to 15 places |
| dir_i | input | 1 | 0 selects a left shift, 1 selects a right shift |
| arith_i | input | 1 | With a right shift: 1 fills with the sign bit, 0 fills with zeros. Ignored for a left shift |
| result_o | output | 32 | Shifted word |

## Verification
The assertions are evaluated combinationally. They assume that every input is a settled 0/1 value whenever the assertions are evaluated, because the block has no clock to qualify them. The bench drives all four inputs together in a single step, away from the sampling edge. Each input vector is held for a whole cycle, so the assertions see a fully settled input set. The sweep covers all 16 counts in each of the four direction and signedness combinations. It uses random words plus the words that matter most for fill and rounding: all ones, only the sign bit, -5, and alternating patterns.

// File: rtl/shf_pkg.sv
package shf_pkg;
  localparam int DATA_W    = 32;
  localparam int COUNT_W   = 4;
  localparam int DIGIT_W   = 2;
  localparam int MUX_WAYS  = 1 << DIGIT_W;
  localparam int NUM_STAGE = COUNT_W / DIGIT_W;

  typedef enum logic [1:0] {
    MODE_LEFT  = 2'b00,
    MODE_LRS   = 2'b10,
    MODE_ARS   = 2'b11
  } shf_mode_e;
endpackage

// File: rtl/shf_mux4.sv
module shf_mux4 #(
  parameter int SEL_W = shf_pkg::DIGIT_W,
  localparam int WAYS = 1 << SEL_W
) (
  input  logic [WAYS-1:0]  cand_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pick_o
);
  always_comb begin
    pick_o = cand_i[sel_i];
  end
endmodule

// File: rtl/shf_fill.sv
module shf_fill (
  input  logic dir_i,
  input  logic arith_i,
  input  logic msb_i,
  output logic fill_o
);
  always_comb begin
    fill_o = dir_i & arith_i & msb_i;
  end
endmodule

// File: rtl/shf_stage.sv
module shf_stage #(
  parameter int W     = shf_pkg::DATA_W,
  parameter int SEL_W = shf_pkg::DIGIT_W,
  parameter int STEP  = 1,
  localparam int WAYS = 1 << SEL_W
) (
  input  logic [W-1:0]     word_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             dir_i,
  input  logic             fill_i,
  output logic [W-1:0]     word_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [WAYS-1:0] cand_r;
    logic [WAYS-1:0] cand_l;
    logic [WAYS-1:0] cand;
    for (genvar k = 0; k < WAYS; k++) begin : g_way
      localparam int SRC_R = i + k * STEP;
      localparam int SRC_L = i - k * STEP;
      if (SRC_R < W) begin : g_r_in
        assign cand_r[k] = word_i[SRC_R];
      end else begin : g_r_fill
        assign cand_r[k] = fill_i;
      end
      if (SRC_L >= 0) begin : g_l_in
        assign cand_l[k] = word_i[SRC_L];
      end else begin : g_l_zero
        assign cand_l[k] = 1'b0;
      end
    end
    assign cand = dir_i ? cand_r : cand_l;
    shf_mux4 #(.SEL_W(SEL_W)) u_mux (
      .cand_i (cand),
      .sel_i  (sel_i),
      .pick_o (word_o[i])
    );
  end
endmodule

// File: rtl/barrel_fill_shifter.sv
module barrel_fill_shifter #(
  parameter int W  = shf_pkg::DATA_W,
  parameter int CW = shf_pkg::COUNT_W,
  localparam int DW   = shf_pkg::DIGIT_W,
  localparam int NSTG = CW / DW
) (
  input  logic [W-1:0]  data_i,
  input  logic [CW-1:0] count_i,
  input  logic          dir_i,
  input  logic          arith_i,
  output logic [W-1:0]  result_o
);
  logic [W-1:0] chain [0:NSTG];
  logic         fill;

  shf_fill u_fill (
    .dir_i   (dir_i),
    .arith_i (arith_i),
    .msb_i   (data_i[W-1]),
    .fill_o  (fill)
  );

  assign chain[0] = data_i;

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    shf_stage #(.W(W), .SEL_W(DW), .STEP(1 << (DW * s))) u_stage (
      .word_i (chain[s]),
      .sel_i  (count_i[DW*s +: DW]),
      .dir_i  (dir_i),
      .fill_i (fill),
      .word_o (chain[s+1])
    );
  end

  assign result_o = chain[NSTG];

  // Masks for the bits that empty out at either end of the word
  logic [W-1:0] lo_mask;
  logic [W-1:0] hi_mask;
  always_comb begin
    lo_mask = (W'(1) << count_i) - W'(1);
    hi_mask = ~({W{1'b1}} >> count_i);
  end

  always_comb begin
    if (count_i == '0) begin
      assert_pass_zero_R1: assert (result_o == data_i);
    end
    if (!dir_i) begin
      assert_left_lowzero_R2: assert ((result_o & lo_mask) == '0);
    end
    if (dir_i && !arith_i) begin
      assert_lrs_highzero_R3: assert ((result_o & hi_mask) == '0);
    end
    if (dir_i && arith_i) begin
      assert_ars_signfill_R4:
        assert ((result_o & hi_mask) == (data_i[W-1] ? hi_mask : '0));
    end
  end
endmodule

// File: tb/tb_barrel_fill_shifter.sv
module tb_barrel_fill_shifter;
  logic        clk;
  logic        rst_n;
  logic [31:0] data_i;
  logic [3:0]  count_i;
  logic        dir_i;
  logic        arith_i;
  logic [31:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  barrel_fill_shifter dut (
    .data_i   (data_i),
    .count_i  (count_i),
    .dir_i    (dir_i),
    .arith_i  (arith_i),
    .result_o (result_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] model(input logic [31:0] d, input int c,
                                        input logic dr, input logic ar);
    logic [63:0] prod;
    if (!dr) begin
      prod = {32'd0, d} * (64'd1 << c);
      return prod[31:0];
    end else if (!ar) begin
      return d / (32'd1 << c);
    end
    return $unsigned($signed(d) >>> c);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: d=%h c=%0d dir=%0b ar=%0b actual=%h expected=%h",
               req, data_i, count_i, dir_i, arith_i, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] d, input int c, input logic dr, input logic ar);
    @(negedge clk);
    data_i = d; count_i = 4'(c); dir_i = dr; arith_i = ar;
    @(posedge clk);
    #1;
  endtask

  task automatic run_vec(input logic [31:0] d, input int c, input logic dr, input logic ar);
    string tag;
    apply(d, c, dr, ar);
    if (c == 0)       tag = "R1";
    else if (c == 15) tag = "R7";
    else if (!dr)     tag = ar ? "R6" : "R2";
    else              tag = ar ? "R4" : "R3";
    check(tag, result_o, model(d, c, dr, ar));
  endtask

  initial begin
    rst_n = 1'b0;
    data_i = '0; count_i = '0; dir_i = 1'b0; arith_i = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", result_o, 32'h0);

    // R5: rounding toward negative infinity
    apply(32'hFFFF_FFFB, 1, 1'b1, 1'b1);
    check("R5", result_o, 32'hFFFF_FFFD);
    apply(32'hFFFF_FFFB, 2, 1'b1, 1'b1);
    check("R5", result_o, 32'hFFFF_FFFE);

    // R7: max count corners
    apply(32'hFFFF_FFFF, 15, 1'b0, 1'b0);
    check("R7", result_o, 32'hFFFF_8000);
    apply(32'h8000_0000, 15, 1'b1, 1'b1);
    check("R7", result_o, 32'hFFFF_0000);
    apply(32'h8000_0000, 15, 1'b1, 1'b0);
    check("R7", result_o, 32'h0001_0000);
    apply(32'h0000_0001, 12, 1'b0, 1'b0);
    check("R7", result_o, 32'h0000_1000);

    // R6: arith ignored in left shifts
    apply(32'h8765_4321, 5, 1'b0, 1'b1);
    check("R6", result_o, 32'hECA8_6420);

    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 16; c++) begin
        run_vec(32'hFFFF_FFFF, c, m[1], m[0]);
        run_vec(32'h8000_0000, c, m[1], m[0]);
        run_vec(32'hFFFF_FFFB, c, m[1], m[0]);
        run_vec(32'hAAAA_5555, c, m[1], m[0]);
        run_vec(32'h0000_0001, c, m[1], m[0]);
        for (int n = 0; n < 24; n++) begin
          run_vec($urandom, c, m[1], m[0]);
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule